// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial port: a data line, a serial clock and a load strobe. Each serial word is 19 bits long, sent most significant bit first. The bit that arrives last is a routing flag that picks one of two destination register sets. One set holds a 14-bit reference division ratio together with four mode bits: prescaler modulus select, phase polarity, monitor output select and pump current select. The other set holds the feedback divider's 7-bit swallow count and 11-bit main count.

The serial lines run asynchronously to the system clock. They are synchronized, and their edges are detected in the system clock domain. A rising serial clock shifts one bit in, unless the load line is high. A rising load line copies the captured word into the set that the routing flag selects. The set that was written pulses its own update strobe for one cycle. A pending flag tells the surrounding logic that at least one set has not yet received a word since reset. A reference word whose ratio is below 3 is a forbidden setting and is dropped.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset every latched field reads zero, both update strobes are low and `cfg_pending` is high.
- R2: Each rising edge of `ser_clk` while `ser_load` is low shifts the current `ser_dat` value into a 19-bit register, first bit sent ending at the top. When more than 19 bits arrive before a load, only the last 19 are kept. Bit k (k = 1..19) below means the bit that was followed by k-1 further bits, so bit 1 is the last one shifted.
- R3: When bit 1 is 1, a load writes `ref_ratio` from bits 2..15 (bit 2 is the least significant). It writes `pre_sel` from bit 16, `phase_inv` from bit 17, `mon_sel` from bit 18 and `pump_hi` from bit 19.
- R4: When bit 1 is 0, a load writes `swallow` from bits 2..8 (bit 2 least significant) and `main_div` from bits 9..19 (bit 9 least significant).
- R5: Latched fields change only at a rising edge of `ser_load`. Only the set selected by bit 1 changes, and the other set keeps its values.
- R6: A word with bit 1 set and a ratio field below 3 is rejected. No field changes, no strobe fires and the reference set does not count as written. Ratios of 3 and above, up to 16383, are accepted.
- R7: A write to the reference set raises `ref_upd` for exactly one cycle, and a write to the feedback set raises `fb_upd` for exactly one cycle. The two strobes never fire together.
- R8: `cfg_pending` stays high until each set has been written at least once, then stays low until reset.
- R9: Rising edges of `ser_clk` while `ser_load` is high leave the shift register unchanged. A later load therefore writes the word that was captured before `ser_load` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, rising edge transfers the word |
| ref_ratio | output | 14 | Latched reference division ratio |
| pre_sel | output | 1 | Latched prescaler modulus select |
| phase_inv | output | 1 | Latched phase polarity |
| mon_sel | output | 1 | Latched monitor output select |
| pump_hi | output | 1 | Latched pump current select |
| swallow | output | 7 | Latched swallow count |
| main_div | output | 11 | Latched main count |
| ref_upd | output | 1 | One-cycle pulse on a reference set write |
| fb_upd | output | 1 | One-cycle pulse on a feedback set write |
| cfg_pending | output | 1 | High until both sets have been written once |

## Verification
The assertions assume that each serial line is stable for several system clock cycles around every edge, so that all three synchronizers deliver a consistent picture. They also assume that `ser_dat` has settled before `ser_clk` rises. Under that assumption, the latched fields may move only in the cycle that shows a strobe, and an accepted reference ratio is never below 3. The stimulus holds each level for at least three system cycles before the next serial edge. It changes data only while the serial clock is low, and it spaces load pulses well apart. Random words are mixed with directed cases: ratios 2 and 3, all-ones fields, extra leading bits, and clocking while the load line is high.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned REF_W   = 14;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned SWL_W   = 7;
  localparam int unsigned MAIN_W  = 11;
  localparam int unsigned FRAME_W = 1 + SWL_W + MAIN_W;
  localparam int unsigned MIN_REF = 3;

  typedef struct packed {
    logic pump_hi;
    logic mon_sel;
    logic phase_inv;
    logic pre_sel;
  } mode_t;

  typedef struct packed {
    logic [REF_W-1:0] ratio;
    mode_t            mode;
  } ref_set_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_div;
    logic [SWL_W-1:0]  swallow;
  } fb_set_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               load_s,
  input  logic               din_s,
  output logic [FRAME_W-1:0] frame,
  output logic               load_pulse
);
  logic               sclk_q, load_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               shift_en;

  always_comb begin
    shift_en   = sclk_s & ~sclk_q & ~load_s;
    load_pulse = load_s & ~load_q;
    shreg_d    = shreg_q;
    if (shift_en) shreg_d = {shreg_q[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
      shreg_q <= '0;
    end else begin
      sclk_q <= sclk_s;
      load_q <= load_s;
      if (shift_en) shreg_q <= shreg_d;
    end
  end

  assign frame = shreg_q;
endmodule

// File: rtl/cfg_bank_route.sv
module cfg_bank_route
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame,
  input  logic               load_pulse,
  output ref_set_t           ref_q,
  output fb_set_t            fb_q,
  output logic               ref_upd,
  output logic               fb_upd,
  output logic               pending
);
  localparam logic [REF_W-1:0] REF_FLOOR = REF_W'(MIN_REF);
  localparam int unsigned      MODE_LO   = REF_W + 1;

  logic     route_ref, ratio_ok, ref_we, fb_we;
  ref_set_t ref_d;
  fb_set_t  fb_d;
  logic     ref_seen_q, fb_seen_q;

  always_comb begin
    route_ref = frame[0];
    ref_d.ratio          = frame[REF_W:1];
    ref_d.mode.pre_sel   = frame[MODE_LO];
    ref_d.mode.phase_inv = frame[MODE_LO+1];
    ref_d.mode.mon_sel   = frame[MODE_LO+2];
    ref_d.mode.pump_hi   = frame[MODE_LO+3];
    fb_d.swallow         = frame[SWL_W:1];
    fb_d.main_div        = frame[FRAME_W-1:SWL_W+1];
    ratio_ok = (ref_d.ratio >= REF_FLOOR);
    ref_we   = load_pulse & route_ref & ratio_ok;
    fb_we    = load_pulse & ~route_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      fb_q       <= '0;
      ref_upd    <= 1'b0;
      fb_upd     <= 1'b0;
      ref_seen_q <= 1'b0;
      fb_seen_q  <= 1'b0;
    end else begin
      ref_upd <= ref_we;
      fb_upd  <= fb_we;
      if (ref_we) begin
        ref_q      <= ref_d;
        ref_seen_q <= 1'b1;
      end
      if (fb_we) begin
        fb_q      <= fb_d;
        fb_seen_q <= 1'b1;
      end
    end
  end

  assign pending = ~(ref_seen_q & fb_seen_q);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              pre_sel,
  output logic              phase_inv,
  output logic              mon_sel,
  output logic              pump_hi,
  output logic [SWL_W-1:0]  swallow,
  output logic [MAIN_W-1:0] main_div,
  output logic              ref_upd,
  output logic              fb_upd,
  output logic              cfg_pending
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic [2:0]         line_s;
  logic [FRAME_W-1:0] frame;
  logic               load_pulse;
  ref_set_t           ref_q;
  fb_set_t            fb_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({ser_load, ser_clk, ser_dat}),
    .q     (line_s)
  );

  cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sclk_s     (line_s[1]),
    .load_s     (line_s[2]),
    .din_s      (line_s[0]),
    .frame      (frame),
    .load_pulse (load_pulse)
  );

  cfg_bank_route u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame      (frame),
    .load_pulse (load_pulse),
    .ref_q      (ref_q),
    .fb_q       (fb_q),
    .ref_upd    (ref_upd),
    .fb_upd     (fb_upd),
    .pending    (cfg_pending)
  );

  assign ref_ratio = ref_q.ratio;
  assign pre_sel   = ref_q.mode.pre_sel;
  assign phase_inv = ref_q.mode.phase_inv;
  assign mon_sel   = ref_q.mode.mon_sel;
  assign pump_hi   = ref_q.mode.pump_hi;
  assign swallow   = fb_q.swallow;
  assign main_div  = fb_q.main_div;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk
  import cfg_loader_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REF_W-1:0]  ref_ratio,
  input logic              pre_sel,
  input logic              phase_inv,
  input logic              mon_sel,
  input logic              pump_hi,
  input logic [SWL_W-1:0]  swallow,
  input logic [MAIN_W-1:0] main_div,
  input logic              ref_upd,
  input logic              fb_upd,
  input logic              cfg_pending
);
  localparam logic [REF_W-1:0] REF_FLOOR = REF_W'(MIN_REF);

  assert_ref_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  assert_fb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd |=> !fb_upd);
  assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_upd && fb_upd));
  assert_ratio_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |-> (ref_ratio >= REF_FLOOR));
  assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> ($stable(ref_ratio) && $stable({pre_sel, phase_inv, mon_sel, pump_hi})));
  assert_fb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_upd |-> ($stable(swallow) && $stable(main_div)));
  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cfg_pending));
  assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_pending) |-> (ref_upd || fb_upd));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (.*);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  logic        clk, rst_n, ser_clk, ser_dat, ser_load;
  logic [13:0] ref_ratio;
  logic        pre_sel, phase_inv, mon_sel, pump_hi;
  logic [6:0]  swallow;
  logic [10:0] main_div;
  logic        ref_upd, fb_upd, cfg_pending;

  int checks = 0, errors = 0;
  int ref_obs = 0, fb_obs = 0;
  bit done = 0;

  logic [18:0] exp_sh;
  logic [13:0] e_ratio;
  logic [3:0]  e_mode;
  logic [6:0]  e_swl;
  logic [10:0] e_main;
  bit          e_ref_seen, e_fb_seen;
  int          e_ref_cnt, e_fb_cnt;

  cfg_serial_loader u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (ref_upd) ref_obs++;
    if (fb_upd)  fb_obs++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] ref_word(input logic [13:0] r, input logic [3:0] m);
    return {m, r, 1'b1};  // m = {pump, mon, phase, pre}
  endfunction

  function automatic logic [18:0] fb_word(input logic [6:0] a, input logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic apply_model(input logic [18:0] w);
    if (w[0]) begin
      if (w[14:1] >= 14'd3) begin
        e_ratio = w[14:1]; e_mode = w[18:15];
        e_ref_seen = 1; e_ref_cnt++;
      end
    end else begin
      e_swl = w[7:1]; e_main = w[18:8];
      e_fb_seen = 1; e_fb_cnt++;
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); ser_dat = b;
    repeat (3) @(negedge clk); ser_clk = 1;
    repeat (4) @(negedge clk); ser_clk = 0;
    repeat (3) @(negedge clk);
    if (!ser_load) exp_sh = {exp_sh[17:0], b};
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) put_bit(w[i]);
  endtask

  task automatic load_pulse();
    @(negedge clk); ser_load = 1; apply_model(exp_sh);
    repeat (8) @(negedge clk); ser_load = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check({req, " ratio"},  32'(ref_ratio), 32'(e_ratio));
    check({req, " mode"},   32'({pump_hi, mon_sel, phase_inv, pre_sel}), 32'(e_mode));
    check({req, " swal"},   32'(swallow), 32'(e_swl));
    check({req, " main"},   32'(main_div), 32'(e_main));
    check({req, " refcnt R7"}, 32'(ref_obs), 32'(e_ref_cnt));
    check({req, " fbcnt R7"},  32'(fb_obs),  32'(e_fb_cnt));
    check({req, " pending R8"}, 32'(cfg_pending), 32'(!(e_ref_seen && e_fb_seen)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; ser_clk = 0; ser_dat = 0; ser_load = 0;
    exp_sh = '0; e_ratio = '0; e_mode = '0; e_swl = '0; e_main = '0;
    e_ref_seen = 0; e_fb_seen = 0; e_ref_cnt = 0; e_fb_cnt = 0;
    repeat (5) @(negedge clk); rst_n = 1;
    repeat (6) @(negedge clk);
    check_all("R1 reset");
    check("R1 strobes", 32'({ref_upd, fb_upd}), 0);

    // R3 / R6 boundary: ratio 3 accepted
    send_word(ref_word(14'd3, 4'b1010)); load_pulse(); check_all("R3 ratio3 R6");
    // R6: ratio 2 rejected
    send_word(ref_word(14'd2, 4'b0101)); load_pulse(); check_all("R6 ratio2");
    send_word(ref_word(14'd0, 4'b1111)); load_pulse(); check_all("R6 ratio0");
    // R4 / R8: feedback all ones, pending drops
    send_word(fb_word(7'h7f, 11'h7ff)); load_pulse(); check_all("R4 ones R8");
    // R3 all ones, R5 feedback untouched
    send_word(ref_word(14'h3fff, 4'b1111)); load_pulse(); check_all("R3 max R5");
    // R2: extra leading bits are dropped
    put_bit(1); put_bit(0); put_bit(1); put_bit(1);
    send_word(fb_word(7'd5, 11'd9)); load_pulse(); check_all("R2 extra bits R4");
    // R9: clocking while load high is ignored
    @(negedge clk); ser_load = 1; apply_model(exp_sh);
    repeat (8) @(negedge clk);
    send_word(ref_word(14'd100, 4'b0011));
    @(negedge clk); ser_load = 0; repeat (8) @(negedge clk);
    load_pulse(); check_all("R9 load high R5");

    for (int k = 0; k < 40; k++) begin
      int unsigned pre = $urandom % 3;
      for (int j = 0; j < int'(pre); j++) put_bit(1'($urandom));
      if ($urandom % 2) begin
        logic [13:0] r;
        r = ($urandom % 6 == 0) ? 14'($urandom % 3) : 14'($urandom);
        send_word(ref_word(r, 4'($urandom)));
      end else begin
        send_word(fb_word(7'($urandom), 11'($urandom)));
      end
      load_pulse();
      check_all("R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule